// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a 16-bit up-counting timer/counter for the peripheral set of a small 8-bit controller. It counts either a divided internal clock or falling edges of an external event pin. A separate trigger pin can, on a falling edge, either copy the running count into a 16-bit holding register (capture) or load the count from that same register (reload). The holding register also provides the value the count restarts from after an overflow in reload mode.

Two serial-clock select bits turn the block into a baud-rate source. While either bit is set, the timer always reloads on overflow, its overflow flag stays clear, and the trigger pin can no longer move the count or the holding register, although trigger edges still raise the trigger flag. Each select bit chooses whether the serial receive or transmit tick comes from this timer's overflow pulse or from another timer's overflow input.

Software reaches a control register and the two 16-bit registers through a byte-wide write port and a combinational read port. Either flag drives the interrupt request.

Top module: `crt_timer_top`

## Requirements
- R1: After reset the control register, the count and the holding register read 0x00, 0x0000 and 0x0000, and the interrupt request is low.
- R2: The count advances by one per count event only while the run bit (control bit 2) is 1; with run at 0 it holds its value.
- R3: With the source-select bit (control bit 1) at 0, the count advances once every 12 clock cycles, the first advance coming 12 cycles after run is set.
- R4: With the source-select bit at 1, the count advances once per falling edge of the event input, taken through a two-flop synchronizer.
- R5: A count event at 0xFFFF is an overflow: in reload mode (control bit 0 at 0) the count takes the holding register value in the same cycle, the overflow flag (control bit 7) is set, and one overflow pulse is output; carries ripple into the high byte normally.
- R6: In capture mode (control bit 0 at 1) an overflow sets the count to 0x0000, and a trigger falling edge with the trigger-enable bit (control bit 3) at 1 copies the count into the holding register without changing the count.
- R7: In reload mode a trigger falling edge with trigger-enable at 1 loads the count from the holding register.
- R8: A trigger falling edge with trigger-enable at 1 sets the trigger flag (control bit 6); with trigger-enable at 0 the trigger pin changes neither count, holding register nor flags.
- R9: While the receive select (control bit 5) or transmit select (control bit 4) is 1, the timer reloads on overflow whatever control bit 0 holds, never sets the overflow flag, and a trigger edge neither reloads nor captures but still sets the trigger flag.
- R10: The interrupt request is high exactly when either flag is 1; flags stay set until software writes 0 to them through the control register.
- R11: Each serial tick output carries this timer's overflow pulse when its select bit is 1 and the other timer's overflow input when it is 0.
- R12: Register addresses: 0 control, 1 count low byte, 2 count high byte, 3 holding low byte, 4 holding high byte; a write to one byte leaves the other byte intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| event_in | input | 1 | External count source, asynchronous |
| trig_in | input | 1 | Capture/reload trigger, asynchronous |
| alt_ovf_in | input | 1 | Overflow pulse of the other timer |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle pulse per overflow |
| rx_tick | output | 1 | Serial receive clock tick |
| tx_tick | output | 1 | Serial transmit clock tick |

## Verification
The bench drives counts across 0xFFFF in reload, capture and both baud modes, where a design that forgot the forced reload would restart from zero and one that did not mask the flag would raise a spurious interrupt. Trigger edges are applied with the enable off, in each mode and in baud mode, so that a design reloading or capturing when it should not leaves a wrong count or holding value, and one that gated the trigger flag in baud mode leaves the flag clear. An exact count after 120 cycles of internal counting exposes an off-by-one prescaler, and a carry from 0x00FF exposes a broken byte split.

// File: rtl/crt_pkg.sv
// Shared types and register map for the capture/reload timer.
// Assumes an 8-bit register bus and a counter twice that width.
package crt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_HLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_HLD_HI = 3'd4;

    // Control register, MSB first; bit order is decoded by software.
    typedef struct packed {
        logic ovf_flag;   // 7
        logic trg_flag;   // 6
        logic rx_sel;     // 5
        logic tx_sel;     // 4
        logic trg_en;     // 3
        logic run;        // 2
        logic src_ext;    // 1
        logic cap_mode;   // 0
    } ctrl_t;
endpackage

// File: rtl/crt_edge_sync.sv
// Synchronizes an asynchronous input with a flop chain and flags a
// falling edge (a high sample followed by a low one) for one cycle.
// Assumes the input is held at least two clock cycles per level.
module crt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the asynchronous input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign fall = prev & ~chain[STAGES-1];

    a_r4_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/crt_prescaler.sv
// Divides the clock: one tick every DIV cycles while enabled; the phase
// restarts at zero whenever the enable drops. Assumes DIV > 1.
module crt_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Advance the phase counter, wrapping at DIV-1, clearing when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign tick = enable && (phase == LAST);

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/crt_core.sv
// Count and holding registers with overflow, reload and capture.
// Byte writes from software take priority over hardware updates.
module crt_core
    import crt_pkg::*;
#(
    parameter int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_evt,
    input  logic              reload_mode,
    input  logic              trg_reload,
    input  logic              trg_capture,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_hld_lo,
    input  logic              wr_hld_hi,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  hold,
    output logic              ovf
);
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] hld_nxt;

    assign ovf = cnt_evt && (&count);

    // Next count and holding values from events, triggers and writes.
    always_comb begin
        cnt_nxt = count;
        hld_nxt = hold;
        if (cnt_evt) cnt_nxt = ovf ? (reload_mode ? hold : '0) : count + 1'b1;
        if (trg_reload)  cnt_nxt = hold;
        if (trg_capture) hld_nxt = count;
        if (wr_cnt_lo) cnt_nxt[BYTE_W-1:0]     = wbyte;
        if (wr_cnt_hi) cnt_nxt[CNT_W-1:BYTE_W] = wbyte;
        if (wr_hld_lo) hld_nxt[BYTE_W-1:0]     = wbyte;
        if (wr_hld_hi) hld_nxt[CNT_W-1:BYTE_W] = wbyte;
    end

    // Register the count and holding values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            hold  <= '0;
        end else begin
            count <= cnt_nxt;
            hold  <= hld_nxt;
        end
    end

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_evt && !trg_reload && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(count));
    a_r5_overflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && reload_mode && !trg_reload && !wr_cnt_lo && !wr_cnt_hi)
        |=> count == $past(hold));
    a_r6_overflow_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reload_mode && !trg_reload && !wr_cnt_lo && !wr_cnt_hi)
        |=> count == '0);
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_capture && !wr_hld_lo && !wr_hld_hi) |=> hold == $past(count));
endmodule

// File: rtl/crt_timer_top.sv
// Capture/reload timer top: control register, flags, interrupt, event
// source selection and serial tick routing. Reads are combinational.
module crt_timer_top
    import crt_pkg::*;
#(
    parameter int PRESCALE = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              event_in,
    input  logic              trig_in,
    input  logic              alt_ovf_in,
    output logic              irq,
    output logic              ovf_pulse,
    output logic              rx_tick,
    output logic              tx_tick
);
    localparam int CNT_W = 2 * BYTE_W;

    ctrl_t            ctrl;
    ctrl_t            ctrl_w;
    logic             wr_ctrl;
    logic             ev_fall;
    logic             trg_fall;
    logic             pre_tick;
    logic             cnt_evt;
    logic             baud;
    logic             trg_act;
    logic             ovf;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] hold;

    assign ctrl_w  = ctrl_t'(wr_data);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
    assign baud    = ctrl.rx_sel | ctrl.tx_sel;
    assign trg_act = ctrl.trg_en & trg_fall;
    assign cnt_evt = ctrl.run & (ctrl.src_ext ? ev_fall : pre_tick);

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_ev_sync (
        .clk(clk), .rst_n(rst_n), .din(event_in), .fall(ev_fall));

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_trg_sync (
        .clk(clk), .rst_n(rst_n), .din(trig_in), .fall(trg_fall));

    crt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl.run & ~ctrl.src_ext), .tick(pre_tick));

    crt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .cnt_evt(cnt_evt),
        .reload_mode(baud | ~ctrl.cap_mode),
        .trg_reload(trg_act & ~baud & ~ctrl.cap_mode),
        .trg_capture(trg_act & ~baud & ctrl.cap_mode),
        .wr_cnt_lo(wr_en && wr_addr == A_CNT_LO),
        .wr_cnt_hi(wr_en && wr_addr == A_CNT_HI),
        .wr_hld_lo(wr_en && wr_addr == A_HLD_LO),
        .wr_hld_hi(wr_en && wr_addr == A_HLD_HI),
        .wbyte(wr_data),
        .count(count), .hold(hold), .ovf(ovf));

    // Control register: software writes, hardware sets of the two flags win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_w;
            if (ovf && !baud) ctrl.ovf_flag <= 1'b1;
            if (trg_act)      ctrl.trg_flag <= 1'b1;
        end
    end

    // Register the overflow so the pulse output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_pulse <= 1'b0;
        else        ovf_pulse <= ovf;
    end

    assign irq     = ctrl.ovf_flag | ctrl.trg_flag;
    assign rx_tick = ctrl.rx_sel ? ovf_pulse : alt_ovf_in;
    assign tx_tick = ctrl.tx_sel ? ovf_pulse : alt_ovf_in;

    // Read multiplexer over the register map.
    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = ctrl;
            A_CNT_LO: rd_data = count[BYTE_W-1:0];
            A_CNT_HI: rd_data = count[CNT_W-1:BYTE_W];
            A_HLD_LO: rd_data = hold[BYTE_W-1:0];
            A_HLD_HI: rd_data = hold[CNT_W-1:BYTE_W];
            default:  rd_data = '0;
        endcase
    end

    a_r9_no_flag_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ctrl.ovf_flag && !wr_ctrl) |=> !ctrl.ovf_flag);
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ovf_flag && !wr_ctrl) |=> ctrl.ovf_flag);
    a_r10_trg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.trg_flag && !wr_ctrl) |=> ctrl.trg_flag);
    a_r5_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(cnt_evt));
    a_r8_no_flag_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.trg_en && !ctrl.trg_flag && !wr_ctrl) |=> !ctrl.trg_flag);
endmodule

// File: tb/crt_timer_top_tb_top.sv
module crt_timer_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       event_in = 1'b0;
    logic       trig_in = 1'b1;
    logic       alt_ovf_in = 1'b0;
    logic       irq, ovf_pulse, rx_tick, tx_tick;

    int n_checks = 0;
    int n_errors = 0;
    int n_pulse = 0;
    int n_rx = 0;

    always #10 clk = ~clk;

    crt_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .event_in(event_in), .trig_in(trig_in), .alt_ovf_in(alt_ovf_in),
        .irq(irq), .ovf_pulse(ovf_pulse), .rx_tick(rx_tick), .tx_tick(tx_tick));

    always @(posedge clk) begin
        if (ovf_pulse) n_pulse++;
        if (rx_tick)   n_rx++;
    end

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] start;
        logic [15:0] reload;
        logic [7:0]  nev;
        logic [15:0] exp_cnt;
        logic [7:0]  exp_ctrl;
        logic [3:0]  exp_pulse;
    } vec_t;

    // Event-driven counting vectors (R4, R5, R6, R9, R11, R12).
    localparam vec_t VECS [6] = '{
        '{8'h06, 16'h0000, 16'h0000, 8'd5, 16'h0005, 8'h06, 4'd0},
        '{8'h06, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 8'h86, 4'd1},
        '{8'h07, 16'hFFFF, 16'h1234, 8'd2, 16'h0001, 8'h87, 4'd1},
        '{8'h26, 16'hFFFD, 16'hABCD, 8'd4, 16'hABCE, 8'h26, 4'd1},
        '{8'h17, 16'hFFFF, 16'h00F0, 8'd1, 16'h00F0, 8'h17, 4'd1},
        '{8'h06, 16'h00FF, 16'h0000, 8'd1, 16'h0100, 8'h06, 4'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] d);
        logic [7:0] l, h;
        rd8(lo, l);
        rd8(lo + 3'd1, h);
        d = {h, l};
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] h, input logic [7:0] ct);
        wr(3'd0, 8'h00);
        wr(3'd1, c[7:0]);  wr(3'd2, c[15:8]);
        wr(3'd3, h[7:0]);  wr(3'd4, h[15:8]);
        wr(3'd0, ct);
    endtask

    task automatic ev_pulse();
        @(negedge clk); event_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); event_in = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic trg_pulse();
        @(negedge clk); trig_in = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk); trig_in = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd8(3'd0, b);  check("R1 ctrl", b, 8'h00);
        rd16(3'd1, w); check("R1 count", w, 16'h0000);
        rd16(3'd3, w); check("R1 hold", w, 16'h0000);
        check("R1 irq", irq, 1'b0);

        // Vector table walk
        foreach (VECS[i]) begin
            setup(VECS[i].start, VECS[i].reload, 8'h00);
            @(negedge clk); n_pulse = 0; n_rx = 0;
            wr(3'd0, VECS[i].ctrl);
            for (int k = 0; k < int'(VECS[i].nev); k++) ev_pulse();
            repeat (2) @(posedge clk);
            rd16(3'd1, w); check($sformatf("R5 vec%0d count", i), w, VECS[i].exp_cnt);
            rd8(3'd0, b);  check($sformatf("R9 vec%0d ctrl", i), b, VECS[i].exp_ctrl);
            rd16(3'd3, w); check($sformatf("R12 vec%0d hold", i), w, VECS[i].reload);
            check($sformatf("R10 vec%0d irq", i), irq, VECS[i].exp_ctrl[7] | VECS[i].exp_ctrl[6]);
            check($sformatf("R5 vec%0d pulses", i), n_pulse, VECS[i].exp_pulse);
            check($sformatf("R11 vec%0d rx ticks", i), n_rx,
                  VECS[i].ctrl[5] ? VECS[i].exp_pulse : 4'd0);
        end

        // R6 capture on trigger
        setup(16'h4321, 16'h0000, 8'h0F);
        trg_pulse();
        rd16(3'd3, w); check("R6 captured", w, 16'h4321);
        rd16(3'd1, w); check("R6 count kept", w, 16'h4321);
        rd8(3'd0, b);  check("R8 flag on capture", b, 8'h4F);
        check("R10 irq trigger", irq, 1'b1);

        // R7 reload on trigger
        setup(16'h0050, 16'h7777, 8'h0E);
        trg_pulse();
        rd16(3'd1, w); check("R7 reloaded", w, 16'h7777);
        rd8(3'd0, b);  check("R8 flag on reload", b, 8'h4E);

        // R8 trigger ignored when disabled
        setup(16'h0050, 16'h7777, 8'h06);
        trg_pulse();
        rd16(3'd1, w); check("R8 count untouched", w, 16'h0050);
        rd16(3'd3, w); check("R8 hold untouched", w, 16'h7777);
        rd8(3'd0, b);  check("R8 no flag", b, 8'h06);
        check("R8 irq low", irq, 1'b0);

        // R9 baud mode: trigger flags only
        setup(16'h0050, 16'h7777, 8'h1F);
        trg_pulse();
        rd16(3'd1, w); check("R9 no reload", w, 16'h0050);
        rd16(3'd3, w); check("R9 no capture", w, 16'h7777);
        rd8(3'd0, b);  check("R9 trigger flag", b, 8'h5F);

        // R10 software clear
        wr(3'd0, 8'h1F);
        rd8(3'd0, b); check("R10 cleared", b, 8'h1F);
        check("R10 irq cleared", irq, 1'b0);

        // R2 hold with run off
        setup(16'h0010, 16'h0000, 8'h02);
        repeat (3) ev_pulse();
        rd16(3'd1, w); check("R2 held", w, 16'h0010);

        // R3 internal divide-by-12 over 120 cycles
        setup(16'h0000, 16'h0000, 8'h00);
        wr(3'd0, 8'h04);
        repeat (119) @(posedge clk);
        wr(3'd0, 8'h00);
        rd16(3'd1, w); check("R3 prescaled count", w, 16'h000A);

        // R11 tick routing from the other timer
        @(negedge clk); alt_ovf_in = 1'b1;
        #1 check("R11 rx from alt", rx_tick, 1'b1);
        check("R11 tx from alt", tx_tick, 1'b1);
        wr(3'd0, 8'h20);
        #1 check("R11 rx own", rx_tick, 1'b0);
        check("R11 tx alt", tx_tick, 1'b1);
        @(negedge clk); alt_ovf_in = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule